// File: doc/BRIEF.md
# Paged Register Address Decoder

This block sits between a narrow host bus and a clock-and-calendar register space. The bus has only five address bits, so it can see 32 locations at a time. The internal space holds 61 locations. Two selector bits decide what the host currently sees: a page bit and a bank bit. Both live in a status register at address zero, and that register stays visible whatever the selectors hold.

On page 0, the low control addresses lead to one of two overlaid banks of four control registers, chosen by the bank bit. Above them sit the clock counters, the alarm-compare RAM and the snapshot RAM, and these ignore the bank bit. On page 1 the same addresses lead to general-purpose RAM.

For every strobed access the block drives a single select line (one-hot), plus an index within the selected resource. It returns the read data one cycle later through a registered multiplexer. Locations with no resource behind them read as zero and take no write.

Top module: `paged_reg_decoder`

## Requirements
- R1: After synchronous reset the page and bank bits are 0, `rvalid` and `rdata` are 0, and a status read returns 0x00.
- R2: Address 0 reaches the status register for every page and bank setting. It drives no resource select. A read returns page in bit 7, bank in bit 6, and 0 in bits 5..0.
- R3: A write to address 0 loads page from `wdata[7]` and bank from `wdata[6]`, and the next cycle decodes with the new values. A write to any other address leaves both bits unchanged.
- R4: On page 0, addresses 1..4 with bank 0 assert `ctl_sel[addr-1]`, and with bank 1 assert `ctl_sel[addr+3]`. `res_idx` equals that same bit number, and a read returns `ctl_rdata`.
- R5: On page 0, addresses 5..15 assert `cnt_sel` with `res_idx = addr-5`, for either bank value. A read returns `cnt_rdata`.
- R6: On page 0, addresses 16..21 assert `cmp_sel` with `res_idx = addr-16`, and addresses 22..26 assert `tsv_sel` with `res_idx = addr-22`, for either bank value. A read returns `cmp_rdata` or `tsv_rdata` respectively.
- R7: On page 1, addresses 1..30 assert `gp_sel` with `res_idx = addr-1`, for either bank value. A read returns `gp_rdata`.
- R8: Page 0 addresses 27..31 and page 1 address 31 are unmapped. They drive no select, read as 0, and a write to them changes neither selector bit.
- R9: Select lines are asserted only while `rd` or `wr` is high, and never more than one at a time. `res_idx` is 0 for the status register and for unmapped addresses.
- R10: `rdata` and `rvalid` are registered. They reflect a read in the cycle after `rd` and are 0 in a cycle after no read. When `rd` and `wr` hit address 0 together, the read returns the selector bits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Host address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| ctl_rdata | input | 8 | Read data from the selected control register |
| cnt_rdata | input | 8 | Read data from the selected clock counter |
| cmp_rdata | input | 8 | Read data from the selected compare RAM entry |
| tsv_rdata | input | 8 | Read data from the selected snapshot RAM entry |
| gp_rdata | input | 8 | Read data from the selected general-purpose RAM entry |
| ctl_sel | output | 8 | One-hot control register select, bank 0 in bits 3..0, bank 1 in bits 7..4 |
| cnt_sel | output | 1 | Clock counter group select |
| cmp_sel | output | 1 | Compare RAM select |
| tsv_sel | output | 1 | Snapshot RAM select |
| gp_sel | output | 1 | General-purpose RAM select |
| res_idx | output | 5 | Index within the selected resource |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Registered read-valid |

## Verification
Two functions can land in the same cycle: a read of the status register and a write that changes the selectors. The bench provokes this by raising `rd` and `wr` together at address 0 with new selector values. It expects `rdata` to show the old page and bank bits, and a following read to show the new ones. Mapping changes are checked the same way from the other side. Each page and bank combination is written and then followed at once by a full 32-address sweep. The expected select, index and data come from arithmetic on the address.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [2:0] {
    RC_NONE = 3'd0,
    RC_MSR  = 3'd1,
    RC_CTL  = 3'd2,
    RC_CNT  = 3'd3,
    RC_CMP  = 3'd4,
    RC_TSV  = 3'd5,
    RC_GP   = 3'd6
  } res_cls_e;
endpackage

// File: rtl/prd_status.sv
module prd_status #(
  parameter int DW     = 8,
  parameter int PS_BIT = 7,
  parameter int RS_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          ps,
  output logic          rs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ps <= 1'b0;
      rs <= 1'b0;
    end else if (we) begin
      ps <= wdata[PS_BIT];
      rs <= wdata[RS_BIT];
    end
  end

  // R3: the selector bits follow the write data one cycle later
  p_sel_load_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> (ps == $past(wdata[PS_BIT])) && (rs == $past(wdata[RS_BIT])));

  // R3: without a status write the selectors hold
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ps) && $stable(rs));
endmodule

// File: rtl/prd_decode.sv
module prd_decode
  import prd_pkg::*;
#(
  parameter int AW    = 5,
  parameter int CTL_N = 4,
  parameter int CNT_N = 11,
  parameter int CMP_N = 6,
  parameter int TSV_N = 5,
  parameter int GP_N  = 30
) (
  input  logic [AW-1:0] addr,
  input  logic          ps,
  input  logic          rs,
  output res_cls_e      cls,
  output logic [AW-1:0] idx
);
  localparam int CTL_B  = 1;
  localparam int CNT_B  = CTL_B + CTL_N;
  localparam int CMP_B  = CNT_B + CNT_N;
  localparam int TSV_B  = CMP_B + CMP_N;
  localparam int FREE_B = TSV_B + TSV_N;

  localparam logic [AW-1:0] A_CTL  = AW'(CTL_B);
  localparam logic [AW-1:0] A_CNT  = AW'(CNT_B);
  localparam logic [AW-1:0] A_CMP  = AW'(CMP_B);
  localparam logic [AW-1:0] A_TSV  = AW'(TSV_B);
  localparam logic [AW-1:0] A_FREE = AW'(FREE_B);
  localparam logic [AW-1:0] A_GPL  = AW'(GP_N);
  localparam logic [AW-1:0] BANK   = AW'(CTL_N);

  always_comb begin
    cls = RC_NONE;
    idx = '0;
    if (addr == '0) begin
      cls = RC_MSR;
    end else if (ps) begin
      if (addr <= A_GPL) begin
        cls = RC_GP;
        idx = addr - A_CTL;
      end
    end else if (addr < A_CNT) begin
      cls = RC_CTL;
      idx = (addr - A_CTL) + (rs ? BANK : '0);
    end else if (addr < A_CMP) begin
      cls = RC_CNT;
      idx = addr - A_CNT;
    end else if (addr < A_TSV) begin
      cls = RC_CMP;
      idx = addr - A_CMP;
    end else if (addr < A_FREE) begin
      cls = RC_TSV;
      idx = addr - A_TSV;
    end
  end
endmodule

// File: rtl/prd_rmux.sv
module prd_rmux
  import prd_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PS_BIT = 7,
  parameter int RS_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  res_cls_e      cls,
  input  logic          ps,
  input  logic          rs,
  input  logic [DW-1:0] ctl_rdata,
  input  logic [DW-1:0] cnt_rdata,
  input  logic [DW-1:0] cmp_rdata,
  input  logic [DW-1:0] tsv_rdata,
  input  logic [DW-1:0] gp_rdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] msr_val;
  logic [DW-1:0] mux_val;

  always_comb begin
    msr_val         = '0;
    msr_val[PS_BIT] = ps;
    msr_val[RS_BIT] = rs;
  end

  always_comb begin
    unique case (cls)
      RC_MSR:  mux_val = msr_val;
      RC_CTL:  mux_val = ctl_rdata;
      RC_CNT:  mux_val = cnt_rdata;
      RC_CMP:  mux_val = cmp_rdata;
      RC_TSV:  mux_val = tsv_rdata;
      RC_GP:   mux_val = gp_rdata;
      default: mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd ? mux_val : '0;
      rvalid <= rd;
    end
  end

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && cls == RC_NONE) |=> (rdata == '0));

  // R10: valid and data appear the cycle after the strobe
  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (!rvalid && rdata == '0));
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
  import prd_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 8,
  parameter int PS_BIT = 7,
  parameter int RS_BIT = 6,
  parameter int CTL_N  = 4,
  parameter int CNT_N  = 11,
  parameter int CMP_N  = 6,
  parameter int TSV_N  = 5,
  parameter int GP_N   = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DW-1:0]      wdata,
  input  logic [DW-1:0]      ctl_rdata,
  input  logic [DW-1:0]      cnt_rdata,
  input  logic [DW-1:0]      cmp_rdata,
  input  logic [DW-1:0]      tsv_rdata,
  input  logic [DW-1:0]      gp_rdata,
  output logic [2*CTL_N-1:0] ctl_sel,
  output logic               cnt_sel,
  output logic               cmp_sel,
  output logic               tsv_sel,
  output logic               gp_sel,
  output logic [AW-1:0]      res_idx,
  output logic [DW-1:0]      rdata,
  output logic               rvalid
);
  localparam int CTL_TOT = 2 * CTL_N;

  res_cls_e      cls;
  logic [AW-1:0] idx;
  logic          ps;
  logic          rs;
  logic          acc;
  logic          msr_we;

  assign acc    = rd | wr;
  assign msr_we = wr && (cls == RC_MSR);

  prd_status #(.DW(DW), .PS_BIT(PS_BIT), .RS_BIT(RS_BIT)) u_status (
    .clk(clk), .rst(rst), .we(msr_we), .wdata(wdata), .ps(ps), .rs(rs)
  );

  prd_decode #(
    .AW(AW), .CTL_N(CTL_N), .CNT_N(CNT_N), .CMP_N(CMP_N),
    .TSV_N(TSV_N), .GP_N(GP_N)
  ) u_decode (
    .addr(addr), .ps(ps), .rs(rs), .cls(cls), .idx(idx)
  );

  for (genvar i = 0; i < CTL_TOT; i++) begin : g_ctl_sel
    assign ctl_sel[i] = acc && (cls == RC_CTL) && (idx == AW'(i));
  end

  assign cnt_sel = acc && (cls == RC_CNT);
  assign cmp_sel = acc && (cls == RC_CMP);
  assign tsv_sel = acc && (cls == RC_TSV);
  assign gp_sel  = acc && (cls == RC_GP);
  assign res_idx = idx;

  prd_rmux #(.DW(DW), .PS_BIT(PS_BIT), .RS_BIT(RS_BIT)) u_rmux (
    .clk(clk), .rst(rst), .rd(rd), .cls(cls), .ps(ps), .rs(rs),
    .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata), .cmp_rdata(cmp_rdata),
    .tsv_rdata(tsv_rdata), .gp_rdata(gp_rdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  // R9: at most one resource select at a time
  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel}));

  // R9: no select without a strobe
  p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd || wr) |-> ({ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel} == '0));

  // R2: address zero never reaches a paged resource
  p_msr_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |-> ({ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel} == '0));

  // R7: general-purpose RAM only on page 1
  p_gp_page_r7: assert property (@(posedge clk) disable iff (rst)
    gp_sel |-> ps);

  // R4: each control bank answers only to its bank value
  p_bank_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (|ctl_sel[CTL_N-1:0]) |-> (!rs && !ps));
  p_bank_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (|ctl_sel[CTL_TOT-1:CTL_N]) |-> (rs && !ps));

  // R3: a status write alters the mapping on the following cycle
  p_map_update_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == '0) |=> (ps == $past(wdata[PS_BIT])));
endmodule

// File: tb/paged_reg_decoder_tb.sv
module paged_reg_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctl_rdata, cnt_rdata, cmp_rdata, tsv_rdata, gp_rdata;
  logic [7:0] ctl_sel;
  logic       cnt_sel, cmp_sel, tsv_sel, gp_sel;
  logic [4:0] res_idx;
  logic [7:0] rdata;
  logic       rvalid;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // resources answer with a class tag plus the index they are given
  assign ctl_rdata = 8'h10 + {3'b0, res_idx};
  assign cnt_rdata = 8'h40 + {3'b0, res_idx};
  assign cmp_rdata = 8'h80 + {3'b0, res_idx};
  assign tsv_rdata = 8'hA0 + {3'b0, res_idx};
  assign gp_rdata  = 8'hC0 + {3'b0, res_idx};

  paged_reg_decoder u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata), .cmp_rdata(cmp_rdata),
    .tsv_rdata(tsv_rdata), .gp_rdata(gp_rdata),
    .ctl_sel(ctl_sel), .cnt_sel(cnt_sel), .cmp_sel(cmp_sel),
    .tsv_sel(tsv_sel), .gp_sel(gp_sel), .res_idx(res_idx),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // class codes: 0 none, 1 status, 2 ctl, 3 cnt, 4 cmp, 5 tsv, 6 gp
  function automatic void model(input bit p, input bit b, input int a,
                                output int c, output int ix);
    c = 0; ix = 0;
    if (a == 0) c = 1;
    else if (p) begin
      if (a <= 30) begin c = 6; ix = a - 1; end
    end
    else if (a <= 4)  begin c = 2; ix = a - 1 + (b ? 4 : 0); end
    else if (a <= 15) begin c = 3; ix = a - 5; end
    else if (a <= 21) begin c = 4; ix = a - 16; end
    else if (a <= 26) begin c = 5; ix = a - 22; end
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int exp_data(input int c, input int ix, input bit p, input bit b);
    case (c)
      1: return {p, b, 6'b0};
      2: return 8'h10 + ix;
      3: return 8'h40 + ix;
      4: return 8'h80 + ix;
      5: return 8'hA0 + ix;
      6: return 8'hC0 + ix;
      default: return 0;
    endcase
  endfunction

  task automatic wr_bus(input int a, input int d);
    @(negedge clk);
    addr = 5'(a); wdata = 8'(d); wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_check(input bit p, input bit b, input int a);
    int c, ix, sel_act, sel_exp;
    model(p, b, a, c, ix);
    @(negedge clk);
    addr = 5'(a); rd = 1'b1; wr = 1'b0;
    #1;
    sel_act = {ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel, res_idx};
    sel_exp = {(c == 2) ? (8'd1 << ix) : 8'd0, c == 3, c == 4, c == 5, c == 6, 5'(ix)};
    chk(sel_act == sel_exp, tag_of(c), sel_act, sel_exp);
    @(negedge clk);
    rd = 1'b0;
    chk(rvalid && rdata == 8'(exp_data(c, ix, p, b)), "R10", {rvalid, rdata},
        {1'b1, 8'(exp_data(c, ix, p, b))});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!rvalid && rdata == 0, "R1", {rvalid, rdata}, 0);
    rd_check(1'b0, 1'b0, 0);

    // R2 R4 R5 R6 R7 R8: sweep every address under every selector value
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        wr_bus(0, {p[0], b[0], 6'h2D});
        for (int a = 0; a < 32; a++) rd_check(p[0], b[0], a);
      end
    end

    // R8: writes to unmapped locations select nothing and leave the selectors
    wr_bus(0, 8'h40);
    for (int a = 27; a < 32; a++) begin
      @(negedge clk);
      addr = 5'(a); wdata = 8'hFF; wr = 1'b1;
      #1;
      chk({ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel} == 0, "R8",
          {ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel}, 0);
      @(negedge clk);
      wr = 1'b0;
    end
    rd_check(1'b0, 1'b1, 0);
    wr_bus(0, 8'h80);
    wr_bus(31, 8'h00);
    rd_check(1'b1, 1'b0, 0);
    rd_check(1'b1, 1'b0, 31);

    // R3: a write to a mapped non-status address keeps the selectors
    wr_bus(5, 8'h00);
    rd_check(1'b1, 1'b0, 0);
    wr_bus(0, 8'h00);
    wr_bus(5, 8'hC0);
    rd_check(1'b0, 1'b0, 0);
    // R3: new mapping used on the very next cycle
    wr_bus(0, 8'h40);
    rd_check(1'b0, 1'b1, 2);

    // R10: read and write of the status register in one cycle
    @(negedge clk);
    addr = 5'd0; wdata = 8'h80; rd = 1'b1; wr = 1'b1;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    chk(rvalid && rdata == 8'h40, "R10", rdata, 8'h40);
    rd_check(1'b1, 1'b0, 0);

    // R9: no select and no read data without strobes
    @(negedge clk);
    addr = 5'd3; rd = 1'b0; wr = 1'b0;
    #1;
    chk({ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel} == 0, "R9",
        {ctl_sel, cnt_sel, cmp_sel, tsv_sel, gp_sel}, 0);
    @(negedge clk);
    chk(!rvalid && rdata == 0, "R10", {rvalid, rdata}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule